// File: doc/BRIEF.md
# Dual 8-bit PWM generator

Two pulse-width modulated outputs run from one shared time base. The system clock is halved, then divided again by a programmable 8-bit prescale value, and each resulting tick advances a common period counter. The counter runs from 0 to 254 and then wraps, so one output period spans 255 ticks. Each channel compares the counter against its own 8-bit duty value and drives one output pin.

Software writes the prescale value and the two duty values over a simple write-only register bus. A new duty value is held in a shadow stage and reaches the comparator only when the counter wraps, so a write in the middle of a period never shortens or splits a pulse. One output period lasts 510 × (P + 1) system clocks, where P is the prescale value.

Top module: `dual_pwm_gen`

## Requirements
- R1: After reset the prescale value and both duty values are 0, and both outputs are high.
- R2: A write is taken on a rising clock edge while wr_en is high. Address 0 selects the prescale value P, address 1 selects the duty value of channel 0, and address 2 selects the duty value of channel 1.
- R3: The period counter advances once every 2 × (P + 1) clocks, stays within 0..254 and wraps from 254 to 0. One output period is therefore 510 × (P + 1) clocks.
- R4: With duty value D, an output is low while the counter is below D and high otherwise. It is low for D × 2 × (P + 1) clocks and high for (255 − D) × 2 × (P + 1) clocks in each period.
- R5: A duty value of 0 gives a constant high output.
- R6: A duty value of 255 gives a constant low output.
- R7: A duty value written mid-period takes effect only at the next counter wrap. The current period finishes with the old value.
- R8: The two channels are independent. Writing the duty value of one channel does not change the waveform of the other.
- R9: A write to address 3 has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 prescale, 1 duty of channel 0, 2 duty of channel 1 |
| wr_data | input | 8 | Write data |
| pwm_out | output | 2 | PWM outputs; bit n belongs to channel n |

## Verification
The hardest case to reach from the ports is a duty write that lands at a known point inside a running period, because the counter itself is not visible. The bench watches a channel until its output rises, which marks the moment the counter reaches the old duty value. It then writes a new value at once. The output must stay high until the wrap, and the new low/high split must appear only in the following period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int PWM_W   = 8;
    localparam int PWM_TOP = (1 << PWM_W) - 2;

    typedef logic [PWM_W-1:0] pwm_word_t;

    localparam pwm_word_t CNT_TOP = pwm_word_t'(PWM_TOP);

    typedef struct packed {
        logic      half;
        pwm_word_t pre_cnt;
        pwm_word_t cnt;
    } tb_state_t;

    typedef struct packed {
        pwm_word_t act;
        logic      out;
    } ch_state_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  pwm_word_t         wr_data,
    output pwm_word_t         presc_o,
    output pwm_word_t         duty_o [NUM_CH]
);

    pwm_word_t presc_d, presc_q;
    pwm_word_t duty_d [NUM_CH];
    pwm_word_t duty_q [NUM_CH];

    always_comb begin
        presc_d = presc_q;
        for (int i = 0; i < NUM_CH; i++) begin
            duty_d[i] = duty_q[i];
        end
        if (wr_en) begin
            if (wr_addr == '0) begin
                presc_d = wr_data;
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (int'(wr_addr) == i + 1) begin
                    duty_d[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                duty_q[i] <= '0;
            end
        end else begin
            presc_q <= presc_d;
            for (int i = 0; i < NUM_CH; i++) begin
                duty_q[i] <= duty_d[i];
            end
        end
    end

    assign presc_o = presc_q;
    assign duty_o  = duty_q;

    // R2: the prescale value changes only through a write to address 0
    a_r2_presc_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == '0) |=> $stable(presc_q));

    // R9: a write to an unmapped address leaves the prescale value alone
    a_r9_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) > NUM_CH) |=> $stable(presc_q));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pwm_word_t presc,
    output pwm_word_t cnt_o,
    output logic      tick_o,
    output logic      wrap_o
);

    tb_state_t st_d, st_q;
    logic      tick;

    always_comb begin
        st_d      = st_q;
        tick      = 1'b0;
        st_d.half = ~st_q.half;
        if (st_q.half) begin
            if (st_q.pre_cnt >= presc) begin
                st_d.pre_cnt = '0;
                tick         = 1'b1;
            end else begin
                st_d.pre_cnt = st_q.pre_cnt + 1'b1;
            end
        end
        if (tick) begin
            st_d.cnt = (st_q.cnt == CNT_TOP) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign tick_o = tick;
    assign wrap_o = tick && (st_q.cnt == CNT_TOP);

    // R3: the counter never leaves 0..254
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_TOP);

    // R3: the divide-by-two stage keeps ticks at least two clocks apart
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R3: the counter moves only on a tick
    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cnt));

    // R3: a tick below the top count steps by exactly one
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.cnt != CNT_TOP) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pwm_word_t duty,
    input  pwm_word_t cnt,
    input  logic      wrap,
    output logic      out_o
);

    ch_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.out = (cnt >= st_q.act);
        if (wrap) begin
            st_d.act = duty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act <= '0;
            st_q.out <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    // R7: the compare value only changes at a wrap
    a_r7_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(st_q.act));

    // R5: a zero compare value keeps the pin high
    a_r5_zero_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act == '0 && $stable(st_q.act)) |=> out_o);

    // R6: a full-scale compare value keeps the pin low
    a_r6_full_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act == '1 && $stable(st_q.act)) |=> !out_o);

endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PWM_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pwm_out
);

    pwm_word_t presc;
    pwm_word_t duty [NUM_CH];
    pwm_word_t cnt;
    logic      tick;
    logic      wrap;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .presc_o (presc),
        .duty_o  (duty)
    );

    pwm_timebase u_tbase (
        .clk    (clk),
        .rst_n  (rst_n),
        .presc  (presc),
        .cnt_o  (cnt),
        .tick_o (tick),
        .wrap_o (wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .duty  (duty[g]),
            .cnt   (cnt),
            .wrap  (wrap),
            .out_o (pwm_out[g])
        );
    end

    // R3: a wrap only happens on a tick
    a_r3_wrap_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> tick);

endmodule

// File: tb/dual_pwm_gen_test.sv
module dual_pwm_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] pwm_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    ch;
        int    exp_low;
        int    exp_high;
        int    settle;
        string tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    dual_pwm_gen uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // driver side: push an expected waveform and wait for the monitor
    task automatic expect_shape(input int ch, input int lo, input int hi,
                                input int p, input string tag);
        exp_t e;
        e.ch = ch; e.exp_low = lo; e.exp_high = hi;
        e.settle = 2 * 510 * (p + 1); e.tag = tag;
        q.push_back(e);
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        prev = pwm_out[ch];
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) return;
            prev = pwm_out[ch];
        end
    endtask

    // monitor: measures the waveform and compares with the queue head
    initial begin
        forever begin
            exp_t e;
            int   hi, lo;
            bit   same;
            logic first;
            while (q.size() == 0) @(negedge clk);
            e = q[0];
            repeat (e.settle) @(negedge clk);
            if (e.exp_low == 0 || e.exp_high == 0) begin
                first = pwm_out[e.ch];
                same  = 1'b1;
                for (int i = 0; i < e.settle; i++) begin
                    @(negedge clk);
                    if (pwm_out[e.ch] !== first) same = 1'b0;
                end
                check(same && (first === (e.exp_low == 0)), e.tag, "constant level",
                      int'(first), int'(e.exp_low == 0));
            end else begin
                wait_rise(e.ch);
                hi = 1;
                for (int i = 0; i < 200000; i++) begin
                    @(negedge clk);
                    if (!pwm_out[e.ch]) break;
                    hi++;
                end
                lo = 1;
                for (int i = 0; i < 200000; i++) begin
                    @(negedge clk);
                    if (pwm_out[e.ch]) break;
                    lo++;
                end
                check(hi == e.exp_high, e.tag, "high clocks", hi, e.exp_high);
                check(lo == e.exp_low, e.tag, "low clocks", lo, e.exp_low);
            end
            void'(q.pop_front());
        end
    end

    initial begin
        bit held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: both outputs high out of reset
        repeat (5) @(negedge clk);
        check(pwm_out == 2'b11, "R1", "outputs after reset", int'(pwm_out), 3);

        // R2 R4: channel 0 duty 100, P = 0 -> low 200, high 310
        wr(2'd1, 8'd100);
        expect_shape(0, 200, 310, 0, "R4");
        // R8: channel 1 untouched stays constant high
        expect_shape(1, 0, 1, 0, "R8");

        // R3: P = 1 doubles the step time; channel 1 duty 30 -> low 120, high 900
        wr(2'd0, 8'd1);
        wr(2'd2, 8'd30);
        expect_shape(1, 120, 900, 1, "R3");
        expect_shape(0, 400, 620, 1, "R8");

        // R5 R6: boundary values at P = 0
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'd255);
        expect_shape(0, 0, 1, 0, "R5");
        expect_shape(1, 1, 0, 0, "R6");

        // R4: near-full duty 254 -> low 508, high 2
        wr(2'd2, 8'd254);
        expect_shape(1, 508, 2, 0, "R4");

        // R9: write to address 3 changes nothing
        wr(2'd3, 8'd7);
        expect_shape(1, 508, 2, 0, "R9");
        expect_shape(0, 0, 1, 0, "R9");

        // R7: mid-period write only applies after the wrap
        wr(2'd1, 8'd100);
        repeat (2 * 510) @(negedge clk);
        wait_rise(0);
        wr(2'd1, 8'd200);
        held = 1'b1;
        for (int i = 0; i < 250; i++) begin
            @(negedge clk);
            if (!pwm_out[0]) held = 1'b0;
        end
        check(held, "R7", "old high phase kept", int'(held), 1);
        expect_shape(0, 400, 110, 0, "R7");

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 190000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule